// File: doc/BRIEF.md
# Serial Port Register Front End with Deferred Interrupts

This block is the host-facing register file of a byte-wide serial port in the 8250 style. A host CPU reaches it over a simple strobe bus with one access per cycle. Register offsets 0 to 7 are decoded, and any other offset is flagged as an error. Behind the registers sit two data paths. One is a receive-byte source, which shows a data-available flag and the byte at its head. The other is a transmit-byte sink, which takes one byte for each push pulse. The serial engine, baud generation and FIFOs live elsewhere.

Receive and transmit interrupts are not raised at once. Each has its own delay timer of `DELAY` clock cycles. Data reads, data writes, writes to the enable register and new receive data start, restart or cancel these timers. When a timer expires, its pending bit is set only if its enable bit is still on. The interrupt output is the OR of the two pending bits. The identification register is reduced to a single pending flag. The line status register always shows the transmitter as empty.

Top module: `serial_reg_front`

## Requirements
- R1: An access with `bus_addr` of 8 or more raises `bus_err` in the same cycle, reads 0 and changes no state. Offsets 0..7 never raise `bus_err`.
- R2: While bit 7 of the line-control register (offset 3) is set, offsets 0 and 1 select the divisor latches. Writes there are discarded, reads return 0, and no byte is pushed or popped.
- R3: A read of offset 0 with bit 7 clear returns `rx_data` and pulses `rx_pop` when `rx_avail` is high. Otherwise it returns 0 with no pop. The read clears the pending receive interrupt.
- R4: One cycle after such a data read, if `rx_avail` is high and enable bit 0 is set, the receive timer restarts. With no data left, it is not restarted.
- R5: A write of offset 0 with bit 7 clear pulses `tx_push` with `tx_data` equal to the written byte, and clears the pending transmit interrupt. If enable bit 1 is set, it also restarts the transmit timer.
- R6: Writing the enable register (offset 1) with bit 1 set starts the transmit timer. Writing it with bit 1 clear cancels that timer and clears the pending transmit interrupt.
- R7: Writing the enable register with bit 0 set while `rx_avail` is high starts the receive timer. Any other enable write cancels the receive timer and clears the pending receive interrupt.
- R8: A rising edge of `rx_avail` starts the receive timer when enable bit 0 is set. The timer is started at the first clock edge that sees the flag high.
- R9: A timer started at clock edge E expires at edge E+`DELAY`. At that edge it sets its pending bit only if its enable bit is set. `irq` is high while either pending bit is set.
- R10: Starting a timer that is already running reloads it to the full `DELAY`.
- R11: Offset 2 reads 0x00 while any interrupt is pending and 0x01 otherwise. Writes to offset 2 have no effect.
- R12: Offset 5 reads 0x60, with bit 0 also set when `rx_avail` is high. Offsets 6 and 7 read 0, and writes to offset 7 are ignored.
- R13: The enable register (offset 1, bit 7 clear), the line-control register (offset 3) and the modem-control register (offset 4) read back the last byte written to them.
- R14: After reset, the enable, line-control and modem-control registers read 0, `irq` is low and offset 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access outside offsets 0..7 |
| rx_avail | input | 1 | Receive source holds at least one byte |
| rx_data | input | 8 | Byte at the head of the receive source |
| rx_pop | output | 1 | Consume the head byte |
| tx_push | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The timers are driven by each kind of start: an enable write, a data write, a rising data flag and the recheck after a read. In every case `irq` is sampled one cycle before and at the expected expiry edge, so an off-by-one in any start path shows up. A second write inside a running window checks that the timer reloads rather than keeps its old deadline. Reads with three bytes queued, one byte, and none tell the restart-on-more-data path apart from the stop-on-empty path. A byte arriving with the enable off shows the enable gate at expiry. A register walk through every offset, with the divisor bit set and cleared and with out-of-range addresses that alias real offsets, checks the decode.

// File: rtl/srf_pkg.sv
// Package: shared offsets, bit positions and channel indices for the
// serial register front end. Channel indices equal the enable-bit positions.
package srf_pkg;
    localparam int unsigned NUM_REGS   = 8;
    localparam int unsigned OFS_W      = 3;
    localparam int unsigned NUM_CH     = 2;
    localparam int unsigned CH_RX      = 0;   // enable bit 0
    localparam int unsigned CH_TX      = 1;   // enable bit 1
    localparam int unsigned DLAB_BIT   = 7;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_IID  = 3'd2,
        OFS_LCTL = 3'd3,
        OFS_MCTL = 3'd4,
        OFS_LSTS = 3'd5,
        OFS_MSTS = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    localparam logic [7:0] LSTS_TX_EMPTY = 8'h60;  // holding and shifter empty
    localparam logic [7:0] IID_NONE      = 8'h01;
    localparam logic [7:0] IID_PENDING   = 8'h00;
endpackage

// File: rtl/srf_delay_timer.sv
// Module: srf_delay_timer
// Down-counter that expires DELAY cycles after the edge that starts it.
// Assumes start has priority over cancel. Expiry is suppressed in any
// cycle with a start or a cancel.
module srf_delay_timer #(
    parameter int unsigned DELAY = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expire,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    // Count register: load on start, clear on cancel, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '0;
        else if (start)            count_q <= LOAD;
        else if (cancel)           count_q <= '0;
        else if (count_q != '0)    count_q <= count_q - 1'b1;
    end

    // Expiry and activity flags.
    always_comb begin
        expire = (count_q == LAST) && !start && !cancel;
        busy   = (count_q != '0);
    end

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LOAD);
    a_r10_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> count_q == LOAD);
    a_r9_expire_idles: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !busy);
endmodule

// File: rtl/srf_read_mux.sv
// Module: srf_read_mux
// Read-data selection for the eight offsets. Pure combinational.
// Assumes the caller gates the result with a valid read.
module srf_read_mux
    import srf_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic             dlab,
    input  logic             rx_avail,
    input  logic [7:0]       rx_data,
    input  logic [7:0]       ien,
    input  logic [7:0]       lctl,
    input  logic [7:0]       mctl,
    input  logic             pend_any,
    output logic [7:0]       rdata
);
    // Offset decode to read value.
    always_comb begin
        rdata = 8'h00;
        unique case (ofs_e'(ofs))
            OFS_DATA: rdata = (!dlab && rx_avail) ? rx_data : 8'h00;
            OFS_IEN:  rdata = dlab ? 8'h00 : ien;
            OFS_IID:  rdata = pend_any ? IID_PENDING : IID_NONE;
            OFS_LCTL: rdata = lctl;
            OFS_MCTL: rdata = mctl;
            OFS_LSTS: rdata = LSTS_TX_EMPTY | {7'd0, rx_avail};
            OFS_MSTS: rdata = 8'h00;
            OFS_SCR:  rdata = 8'h00;
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/serial_reg_front.sv
// Module: serial_reg_front
// Host register front end of a byte serial port with interrupts deferred
// by per-channel timers. Assumes at most one bus access per cycle, and that
// the receive source updates rx_avail at the edge that pops a byte.
module serial_reg_front
    import srf_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DELAY  = 450
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_err,
    input  logic              rx_avail,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NUM_REGS);

    logic [7:0]        ien_q, lctl_q, mctl_q;
    logic [NUM_CH-1:0] pend_q;
    logic              recheck_q, avail_q;
    logic [OFS_W-1:0]  ofs;
    logic              in_range, rd_acc, wr_acc, dlab;
    logic              data_rd, data_wr, ien_wr;
    logic [NUM_CH-1:0] tmr_start, tmr_cancel, tmr_expire, tmr_busy, pend_clr;
    logic [7:0]        mux_rdata;

    // Address decode and access qualification.
    always_comb begin
        in_range = bus_addr < ADDR_LIMIT;
        ofs      = bus_addr[OFS_W-1:0];
        rd_acc   = bus_sel && in_range && !bus_wr;
        wr_acc   = bus_sel && in_range && bus_wr;
        dlab     = lctl_q[DLAB_BIT];
        data_rd  = rd_acc && (ofs == OFS_DATA) && !dlab;
        data_wr  = wr_acc && (ofs == OFS_DATA) && !dlab;
        ien_wr   = wr_acc && (ofs == OFS_IEN) && !dlab;
    end

    // Data path strobes toward source and sink.
    always_comb begin
        bus_err = bus_sel && !in_range;
        rx_pop  = data_rd && rx_avail;
        tx_push = data_wr;
        tx_data = bus_wdata;
        irq     = |pend_q;
    end

    // Timer control: starts, cancels and pending clears for both channels.
    always_comb begin
        tmr_start[CH_TX]  = (data_wr && ien_q[CH_TX]) || (ien_wr && bus_wdata[CH_TX]);
        tmr_cancel[CH_TX] = ien_wr && !bus_wdata[CH_TX];
        pend_clr[CH_TX]   = tmr_cancel[CH_TX] || data_wr;
        tmr_start[CH_RX]  = (ien_wr && bus_wdata[CH_RX] && rx_avail)
                         || (!ien_wr && ien_q[CH_RX] && rx_avail && (recheck_q || !avail_q));
        tmr_cancel[CH_RX] = ien_wr && !(bus_wdata[CH_RX] && rx_avail);
        pend_clr[CH_RX]   = tmr_cancel[CH_RX] || data_rd;
    end

    // Control registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 8'h00;
            lctl_q <= 8'h00;
            mctl_q <= 8'h00;
        end else begin
            if (ien_wr)                            ien_q  <= bus_wdata;
            if (wr_acc && (ofs == OFS_LCTL))       lctl_q <= bus_wdata;
            if (wr_acc && (ofs == OFS_MCTL))       mctl_q <= bus_wdata;
        end
    end

    // History of data reads and of the receive flag, for the restart paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recheck_q <= 1'b0;
            avail_q   <= 1'b0;
        end else begin
            recheck_q <= data_rd;
            avail_q   <= rx_avail;
        end
    end

    // One delay timer and one pending bit per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        srf_delay_timer #(.DELAY(DELAY)) i_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (tmr_start[ch]),
            .cancel (tmr_cancel[ch]),
            .expire (tmr_expire[ch]),
            .busy   (tmr_busy[ch])
        );

        // Pending bit: cleared by its events, set on expiry if enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)                               pend_q[ch] <= 1'b0;
            else if (pend_clr[ch])                    pend_q[ch] <= 1'b0;
            else if (tmr_expire[ch] && ien_q[ch])     pend_q[ch] <= 1'b1;
        end

        a_r9_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[ch]) |-> $past(ien_q[ch]));
    end

    srf_read_mux i_read_mux (
        .ofs      (ofs),
        .dlab     (dlab),
        .rx_avail (rx_avail),
        .rx_data  (rx_data),
        .ien      (ien_q),
        .lctl     (lctl_q),
        .mctl     (mctl_q),
        .pend_any (|pend_q),
        .rdata    (mux_rdata)
    );

    // Read data is driven only for valid in-range reads.
    always_comb bus_rdata = rd_acc ? mux_rdata : 8'h00;

    a_r1_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !tx_push && !rx_pop && bus_rdata == 8'h00);
    a_r2_dlab_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && lctl_q[DLAB_BIT] && in_range && ofs == OFS_DATA) |-> !tx_push && !rx_pop);
    a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_avail);
    a_r5_push_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !pend_q[CH_TX]);
    a_r6_ien_off_cancels_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !bus_wdata[CH_TX]) |=> !pend_q[CH_TX] && !tmr_busy[CH_TX]);
    a_r7_ien_off_cancels_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !bus_wdata[CH_RX]) |=> !pend_q[CH_RX] && !tmr_busy[CH_RX]);
endmodule

// File: tb/test_serial_reg_front.sv
`timescale 1ns/1ps
// Bench: register walk from a vector table, then directed timer tests.
module test_serial_reg_front;
    localparam int unsigned DLY = 6;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wd;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int unsigned NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 4'h3, 8'h03, 8'h00, 4'd13},  // R13 line control
        '{1'b0, 4'h3, 8'h00, 8'h03, 4'd13},
        '{1'b1, 4'h4, 8'h0B, 8'h00, 4'd13},  // R13 modem control
        '{1'b0, 4'h4, 8'h00, 8'h0B, 4'd13},
        '{1'b1, 4'h7, 8'h55, 8'h00, 4'd12},  // R12 scratch ignored
        '{1'b0, 4'h7, 8'h00, 8'h00, 4'd12},
        '{1'b0, 4'h6, 8'h00, 8'h00, 4'd12},
        '{1'b0, 4'h5, 8'h00, 8'h60, 4'd12},
        '{1'b1, 4'h2, 8'hC7, 8'h00, 4'd11},  // R11 write has no effect
        '{1'b0, 4'h2, 8'h00, 8'h01, 4'd11},
        '{1'b1, 4'h3, 8'h83, 8'h00, 4'd2},   // R2 divisor bit on
        '{1'b1, 4'h1, 8'h03, 8'h00, 4'd2},
        '{1'b0, 4'h1, 8'h00, 8'h00, 4'd2},
        '{1'b1, 4'h3, 8'h03, 8'h00, 4'd2},
        '{1'b0, 4'h1, 8'h00, 8'h00, 4'd2},   // enable untouched
        '{1'b0, 4'h9, 8'h00, 8'h00, 4'd1},   // R1 out of range
        '{1'b1, 4'hB, 8'h80, 8'h00, 4'd1},
        '{1'b0, 4'h3, 8'h00, 8'h03, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, tx_data;
    logic       bus_err, rx_pop, tx_push, irq;
    logic [3:0] rx_cnt;
    logic       rx_load = 1'b0;
    logic [3:0] rx_load_val = '0;
    logic       rx_avail;
    logic [7:0] rx_data;

    int n_chk = 0, n_err = 0;
    logic [7:0] cap_rdata, cap_txd;
    logic       cap_err, cap_push, cap_pop;

    always #2.5 clk = ~clk;

    // Receive source model: counted bytes 0x30+count, popped on rx_pop.
    always @(posedge clk) begin
        if (!rst_n)       rx_cnt <= '0;
        else if (rx_load) rx_cnt <= rx_load_val;
        else if (rx_pop)  rx_cnt <= rx_cnt - 1'b1;
    end
    assign rx_avail = (rx_cnt != '0);
    assign rx_data  = 8'h30 + {4'd0, rx_cnt};

    serial_reg_front #(.ADDR_W(4), .DELAY(DLY)) i_serial_reg_front (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rx_avail(rx_avail), .rx_data(rx_data),
        .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        cap_rdata = bus_rdata; cap_err = bus_err; cap_push = tx_push;
        cap_pop = rx_pop; cap_txd = tx_data;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wait_irq(input int n, input string req);
        repeat (n - 1) @(posedge clk);
        #1 chk(req, {7'd0, irq}, 8'h00);
        @(posedge clk);
        #1 chk(req, {7'd0, irq}, 8'h01);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 chk(req, {7'd0, irq}, 8'h00);
        end
    endtask

    task automatic load(input logic [3:0] v);
        @(negedge clk);
        rx_load = 1'b1; rx_load_val = v;
        @(negedge clk);
        rx_load = 1'b0;
    endtask

    task automatic run_tests();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R14 reset state
        chk("R14 irq", {7'd0, irq}, 8'h00);
        bus(1'b0, 4'h1, 8'h00); chk("R14 enable", cap_rdata, 8'h00);
        bus(1'b0, 4'h3, 8'h00); chk("R14 line ctl", cap_rdata, 8'h00);
        bus(1'b0, 4'h4, 8'h00); chk("R14 modem ctl", cap_rdata, 8'h00);
        bus(1'b0, 4'h2, 8'h00); chk("R14 ident", cap_rdata, 8'h01);

        // Register walk
        for (int i = 0; i < int'(NV); i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            bus(TBL[i].wr, TBL[i].addr, TBL[i].wd);
            chk({tag, " err"}, {7'd0, cap_err}, {7'd0, TBL[i].addr >= 4'd8});
            if (!TBL[i].wr) chk(tag, cap_rdata, TBL[i].exp);
        end

        // R6 / R9 transmit timer from enable write
        bus(1'b1, 4'h1, 8'h02);
        wait_irq(DLY, "R6 R9 tx start");
        bus(1'b0, 4'h2, 8'h00); chk("R11 pending ident", cap_rdata, 8'h00);
        bus(1'b0, 4'h1, 8'h00); chk("R13 enable readback", cap_rdata, 8'h02);

        // R5 data write
        bus(1'b1, 4'h0, 8'hA5);
        chk("R5 push", {7'd0, cap_push}, 8'h01);
        chk("R5 tx byte", cap_txd, 8'hA5);
        chk("R5 pend cleared", {7'd0, irq}, 8'h00);
        wait_irq(DLY, "R5 tx restart");

        // R2 data write under divisor bit
        bus(1'b1, 4'h3, 8'h83);
        bus(1'b1, 4'h0, 8'h11);
        chk("R2 no push", {7'd0, cap_push}, 8'h00);
        bus(1'b1, 4'h3, 8'h03);

        // R10 restart reloads
        bus(1'b1, 4'h0, 8'h01);
        @(posedge clk); @(posedge clk);
        bus(1'b1, 4'h0, 8'h02);
        wait_irq(DLY, "R10 reload");

        // R6 cancel
        bus(1'b1, 4'h1, 8'h00);
        chk("R6 cancel clears", {7'd0, irq}, 8'h00);
        quiet(DLY + 3, "R6 stays low");

        // R8 / R3 / R4 receive path
        bus(1'b1, 4'h1, 8'h01);
        load(4'd3);
        wait_irq(DLY + 1, "R8 rising data");
        bus(1'b0, 4'h5, 8'h00); chk("R12 status with data", cap_rdata, 8'h61);
        bus(1'b0, 4'h0, 8'h00);
        chk("R3 byte", cap_rdata, 8'h33);
        chk("R3 pop", {7'd0, cap_pop}, 8'h01);
        chk("R3 pend cleared", {7'd0, irq}, 8'h00);
        wait_irq(DLY + 1, "R4 restart more data");
        bus(1'b0, 4'h0, 8'h00); chk("R3 byte2", cap_rdata, 8'h32);
        wait_irq(DLY + 1, "R4 restart again");
        bus(1'b0, 4'h0, 8'h00); chk("R3 last byte", cap_rdata, 8'h31);
        quiet(DLY + 4, "R4 no restart when empty");
        bus(1'b0, 4'h0, 8'h00);
        chk("R3 empty read", cap_rdata, 8'h00);
        chk("R3 no pop", {7'd0, cap_pop}, 8'h00);

        // R9 enable gate, R7 enable write with waiting data
        bus(1'b1, 4'h1, 8'h00);
        load(4'd1);
        quiet(DLY + 3, "R9 disabled no irq");
        bus(1'b1, 4'h1, 8'h01);
        wait_irq(DLY, "R7 start with data");
        bus(1'b1, 4'h1, 8'h00);
        chk("R7 cancel clears", {7'd0, irq}, 8'h00);
        bus(1'b0, 4'h2, 8'h00); chk("R7 ident none", cap_rdata, 8'h01);
        bus(1'b0, 4'h0, 8'h00); chk("R3 drain", cap_rdata, 8'h31);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule